// File: doc/BRIEF.md
# Processor Run and Status Control Register

This block holds the run state of a small processor core and reports it as one readable status byte. It decides whether the core may fetch and execute. A halt instruction, or an armed single-step, stops the core at the next end-of-instruction strobe. Once stopped, the core stays stopped until a power-on or watchdog reset. Software can also park the core in a low-power suspend state by writing a control bit. Any pending interrupt brings the core back out of suspend.

The byte also shows the interrupt-mask state, which only the DI, EI and RETI instruction pulses can change. It also carries two reset-cause flags, so a reset handler can tell a power-on start from a watchdog recovery. The global and per-endpoint enable gating of interrupts, the instruction decoder and the clock gating live outside this block. So does the saving of the wake-up return address. All state is updated on the rising clock edge. Both reset inputs act synchronously.

Top module: `cpu_runctl`

## Requirements
- R1: On a power-on reset the register reads 0x11: run (bit 0) is 1, the power-on flag (bit 4) is 1, and every other bit is 0. On a watchdog reset alone it reads 0x41: run is 1 and the watchdog flag (bit 6) is 1. If both resets are active together, the power-on result applies.
- R2: A halt strobe is remembered. Run (bit 0) clears on the first end-of-instruction strobe in the same cycle as the halt strobe or any later cycle. The readback and `run_o` show the change one clock later.
- R3: Once run is 0 it stays 0 until a reset. Writes to bit 0 have no effect.
- R4: Bit 1 (single step) is read/write. While it reads 1, the next end-of-instruction strobe clears run.
- R5: Bit 2 (interrupt mask, 1 = enabled) changes as follows. EI or RETI sets it and DI clears it. DI wins when it coincides with EI or RETI. Register writes have no effect on it.
- R6: Writing 1 to bit 3 enters suspend, and writing 0 leaves it. While suspend reads 1, `run_o` is 0.
- R7: A pending interrupt clears suspend on the next edge. This holds even when a write of 1 to bit 3 falls in the same cycle.
- R8: Bits 5 and 7 always read 0. Writes have no effect on the reset-cause flags (bits 4 and 6).
- R9: `run_o` is 1 exactly when run is 1 and suspend is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_i | input | 1 | Power-on reset, active high, synchronous |
| wdog_rst_i | input | 1 | Watchdog reset, active high, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | REG_W | Register write data |
| halt_i | input | 1 | Halt instruction strobe |
| instr_end_i | input | 1 | End of current instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction pulse |
| ei_i | input | 1 | Enable-interrupts instruction pulse |
| reti_i | input | 1 | Return-from-interrupt instruction pulse |
| irq_i | input | 1 | An interrupt is pending |
| run_o | output | 1 | Core may execute |
| rd_data_o | output | REG_W | Register read value |

## Verification
A write of 1 to the suspend bit can land in the same cycle as a pending interrupt. The bench provokes this directly, with a write of 0x08 while the interrupt input is high. It expects suspend to read 0 and `run_o` to stay high on the next cycle. The random phase raises both strobes often enough to repeat the collision many times, and each time it is judged against the bench model. A halt strobe that arrives in the same cycle as its end-of-instruction strobe is covered the same way.

// File: rtl/cpu_runctl_pkg.sv
package cpu_runctl_pkg;

    localparam int unsigned POS_RUN   = 0;
    localparam int unsigned POS_STEP  = 1;
    localparam int unsigned POS_MASK  = 2;
    localparam int unsigned POS_SUSP  = 3;
    localparam int unsigned POS_PORF  = 4;
    localparam int unsigned POS_WDOGF = 6;
    localparam int unsigned POS_TOP   = 6;

    typedef struct packed {
        logic run;
        logic step;
        logic halt_pend;
    } seq_state_t;

    typedef struct packed {
        logic mask;
        logic susp;
    } irq_state_t;

    typedef struct packed {
        logic por_flag;
        logic wdog_flag;
    } cause_state_t;

endpackage

// File: rtl/runctl_seq.sv
module runctl_seq
    import cpu_runctl_pkg::*;
(
    input  logic clk,
    input  logic rst_i,
    input  logic wr_en_i,
    input  logic step_wr_i,
    input  logic halt_i,
    input  logic instr_end_i,
    output logic run_o,
    output logic step_o
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.run       = 1'b1;
            st_d.step      = 1'b0;
            st_d.halt_pend = 1'b0;
        end else begin
            st_d.halt_pend = (st_q.halt_pend | halt_i) & ~instr_end_i;
            if (instr_end_i && (st_q.halt_pend || halt_i || st_q.step)) begin
                st_d.run = 1'b0;
            end
            if (wr_en_i) begin
                st_d.step = step_wr_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign run_o  = st_q.run;
    assign step_o = st_q.step;

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (rst_i)
        (instr_end_i && (st_q.halt_pend || halt_i)) |=> !st_q.run); // R2

    AST_RUN_NO_RISE: assert property (@(posedge clk) disable iff (rst_i)
        !st_q.run |=> !st_q.run); // R3

    AST_STEP_STOPS: assert property (@(posedge clk) disable iff (rst_i)
        (instr_end_i && st_q.step) |=> !st_q.run); // R4

endmodule

// File: rtl/runctl_irq.sv
module runctl_irq
    import cpu_runctl_pkg::*;
(
    input  logic clk,
    input  logic rst_i,
    input  logic wr_en_i,
    input  logic susp_wr_i,
    input  logic di_i,
    input  logic ei_i,
    input  logic reti_i,
    input  logic irq_i,
    output logic mask_o,
    output logic susp_o
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.mask = 1'b0;
            st_d.susp = 1'b0;
        end else begin
            if (di_i) begin
                st_d.mask = 1'b0;
            end else if (ei_i || reti_i) begin
                st_d.mask = 1'b1;
            end
            if (irq_i) begin
                st_d.susp = 1'b0;
            end else if (wr_en_i) begin
                st_d.susp = susp_wr_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign susp_o = st_q.susp;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst_i)
        !(di_i || ei_i || reti_i) |=> $stable(st_q.mask)); // R5

    AST_DI_WINS: assert property (@(posedge clk) disable iff (rst_i)
        di_i |=> !st_q.mask); // R5

    AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (rst_i)
        irq_i |=> !st_q.susp); // R7

endmodule

// File: rtl/cpu_runctl.sv
module cpu_runctl
    import cpu_runctl_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             por_rst_i,
    input  logic             wdog_rst_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             halt_i,
    input  logic             instr_end_i,
    input  logic             di_i,
    input  logic             ei_i,
    input  logic             reti_i,
    input  logic             irq_i,
    output logic             run_o,
    output logic [REG_W-1:0] rd_data_o
);

    localparam int unsigned MIN_W = POS_TOP + 1;

    generate
        if (REG_W < MIN_W) begin : g_bad_width
            initial $error("cpu_runctl: REG_W too small");
        end
    endgenerate

    logic         rst_any;
    logic         run_bit, step_bit, mask_bit, susp_bit;
    cause_state_t cz_d, cz_q;

    assign rst_any = por_rst_i | wdog_rst_i;

    runctl_seq u_seq (
        .clk         (clk),
        .rst_i       (rst_any),
        .wr_en_i     (wr_en_i),
        .step_wr_i   (wr_data_i[POS_STEP]),
        .halt_i      (halt_i),
        .instr_end_i (instr_end_i),
        .run_o       (run_bit),
        .step_o      (step_bit)
    );

    runctl_irq u_irq (
        .clk       (clk),
        .rst_i     (rst_any),
        .wr_en_i   (wr_en_i),
        .susp_wr_i (wr_data_i[POS_SUSP]),
        .di_i      (di_i),
        .ei_i      (ei_i),
        .reti_i    (reti_i),
        .irq_i     (irq_i),
        .mask_o    (mask_bit),
        .susp_o    (susp_bit)
    );

    always_comb begin
        cz_d = cz_q;
        if (por_rst_i) begin
            cz_d.por_flag  = 1'b1;
            cz_d.wdog_flag = 1'b0;
        end else if (wdog_rst_i) begin
            cz_d.por_flag  = 1'b0;
            cz_d.wdog_flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cz_q <= cz_d;
    end

    always_comb begin
        rd_data_o            = '0;
        rd_data_o[POS_RUN]   = run_bit;
        rd_data_o[POS_STEP]  = step_bit;
        rd_data_o[POS_MASK]  = mask_bit;
        rd_data_o[POS_SUSP]  = susp_bit;
        rd_data_o[POS_PORF]  = cz_q.por_flag;
        rd_data_o[POS_WDOGF] = cz_q.wdog_flag;
    end

    assign run_o = run_bit & ~susp_bit;

    AST_CAUSE_EXCL: assert property (@(posedge clk) disable iff (rst_any)
        !(cz_q.por_flag && cz_q.wdog_flag)); // R1

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst_any)
        wr_en_i |=> $stable({cz_q.por_flag, cz_q.wdog_flag})); // R8

endmodule

// File: tb/sim_cpu_runctl.sv
module sim_cpu_runctl;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         por_rst, wdog_rst, wr_en, halt, iend, di, ei, reti, irq;
    logic [W-1:0] wr_data;
    logic         run_o;
    logic [W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic m_run, m_step, m_hp, m_mask, m_susp, m_porf, m_wdogf;

    always #10 clk = ~clk;

    cpu_runctl #(.REG_W(W)) u0 (
        .clk(clk), .por_rst_i(por_rst), .wdog_rst_i(wdog_rst),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .halt_i(halt),
        .instr_end_i(iend), .di_i(di), .ei_i(ei), .reti_i(reti),
        .irq_i(irq), .run_o(run_o), .rd_data_o(rd_data)
    );

    function automatic logic [W-1:0] exp_rd();
        logic [W-1:0] v = '0;
        v[0] = m_run; v[1] = m_step; v[2] = m_mask; v[3] = m_susp;
        v[4] = m_porf; v[6] = m_wdogf;
        return v;
    endfunction

    task automatic model_step();
        if (por_rst || wdog_rst) begin
            m_run = 1; m_step = 0; m_hp = 0; m_mask = 0; m_susp = 0;
            m_porf = por_rst; m_wdogf = !por_rst;
        end else begin
            logic hp_now = m_hp | halt;
            if (iend && (hp_now || m_step)) m_run = 0;
            m_hp = hp_now & ~iend;
            if (wr_en) m_step = wr_data[1];
            if (di) m_mask = 0;
            else if (ei || reti) m_mask = 1;
            if (irq) m_susp = 0;
            else if (wr_en) m_susp = wr_data[3];
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        por_rst = 0; wdog_rst = 0; wr_en = 0; wr_data = '0; halt = 0;
        iend = 0; di = 0; ei = 0; reti = 0; irq = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2/R3 run bit", 32'(rd_data[0]), 32'(m_run));
        chk("R4 step bit", 32'(rd_data[1]), 32'(m_step));
        chk("R5 mask bit", 32'(rd_data[2]), 32'(m_mask));
        chk("R6/R7 suspend bit", 32'(rd_data[3]), 32'(m_susp));
        chk("R1/R8 cause flags", 32'({rd_data[6], rd_data[4]}), 32'({m_wdogf, m_porf}));
        chk("R8 reserved bits", 32'({rd_data[7], rd_data[5]}), 32'd0);
        chk("R9 run_o", 32'(run_o), 32'(m_run & ~m_susp));
        idle();
    endtask

    initial begin
        int lim = 0;
        while (!done && lim < 100000) begin
            @(posedge clk);
            lim++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        por_rst = 1;
        @(negedge clk);
        tick();
        // R1 power-on value
        chk("R1 por value", 32'(rd_data), 32'h11);
        wdog_rst = 1; tick();
        chk("R1 watchdog value", 32'(rd_data), 32'h41);
        por_rst = 1; wdog_rst = 1; tick();
        chk("R1 both resets", 32'(rd_data), 32'h11);
        // R7 collision: suspend write with pending interrupt
        wr_en = 1; wr_data = 8'h08; irq = 1; tick();
        chk("R7 wake beats write", 32'(rd_data[3]), 32'd0);
        chk("R7 run_o stays", 32'(run_o), 32'd1);
        wr_en = 1; wr_data = 8'h08; tick();
        chk("R6 suspend entered", 32'({rd_data[3], run_o}), 32'b10);
        wr_en = 1; wr_data = 8'hFF; tick();
        chk("R8 flags/reserved after 0xFF", 32'(rd_data), 32'h1B);
        di = 1; ei = 1; reti = 1; tick();
        chk("R5 DI wins", 32'(rd_data[2]), 32'd0);
        ei = 1; tick();
        wr_en = 1; wr_data = 8'h00; tick();
        chk("R5 write ignored", 32'(rd_data[2]), 32'd1);
        wr_en = 1; wr_data = 8'h02; tick();
        iend = 1; tick();
        chk("R4 step stops", 32'(rd_data[0]), 32'd0);
        wr_en = 1; wr_data = 8'h01; tick();
        chk("R3 run write ignored", 32'(rd_data[0]), 32'd0);
        por_rst = 1; tick();
        halt = 1; tick();
        chk("R2 pending not yet", 32'(run_o), 32'd1);
        iend = 1; tick();
        chk("R2 halted", 32'(run_o), 32'd0);
        por_rst = 1; tick();
        halt = 1; iend = 1; tick();
        chk("R2 same-cycle halt", 32'(rd_data[0]), 32'd0);
        for (int i = 0; i < 3000; i++) begin
            por_rst  = ($urandom % 48) == 0;
            wdog_rst = ($urandom % 48) == 0;
            halt     = ($urandom % 16) == 0;
            iend     = ($urandom % 2) == 0;
            wr_en    = ($urandom % 4) == 0;
            wr_data  = W'($urandom);
            di       = ($urandom % 8) == 0;
            ei       = ($urandom % 8) == 0;
            reti     = ($urandom % 8) == 0;
            irq      = ($urandom % 6) == 0;
            tick();
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule